// File: doc/BRIEF.md
# ADC Conversion Sequencer with Locked Selection

This controller runs the timing of a successive-approximation converter. A CPU-facing write port fills a holding register with the channel and reference selection at any moment. A second, shadow register drives the analog multiplexer. The shadow register follows the holding register while the converter is idle. It is frozen for the sampling part of each conversion and reopens for the final eight converter cycles. A start comes from a software start strobe, from an external trigger in trigger mode, or in free-running mode from the end of the previous conversion. The converter clock is derived from the system clock by a prescaler. This prescaler is held at zero between conversions, so every conversion begins on a fresh converter-clock boundary. At the end of a conversion a sticky completion flag is raised and the result appears as a high/low byte pair.

The analog front end is replaced by a stub. The stub latches the `ana_code` input at the sample-and-hold point. The result is a register, not a stream. It holds its value until the next completion overwrites it, so it needs no valid/ready handshake and applies no back-pressure. Software watches `done_flag` and clears it by writing one.

Top module: `adc_seq`

## Requirements
- R1: After reset `busy`, `done_flag`, `mux_sel`, `res_hi` and `res_lo` are all zero.
- R2: While idle, a value written with `sel_wr_en` is taken by the holding register on that clock edge and appears on `mux_sel` one edge later.
- R3: A start (strobe or trigger) sampled on edge k begins the conversion on edge k+2. A selection written on edge k+1 still reaches `mux_sel`. One written on edge k+2 or later does not reach it before the release window.
- R4: While a conversion is in progress, `mux_sel` is frozen until the converter cycle count reaches length minus 8. From the following edge it follows the holding register again.
- R5: `done_flag` is set on the completion edge and stays set until `flag_clr` is sampled high, which clears it. A set in the same cycle wins over a clear.
- R6: The first conversion after `en` rises or after reset lasts 25 converter cycles. Each later conversion lasts 13. Completion therefore falls on edge k+2+25·D or k+2+13·D, where D is the division ratio.
- R7: `busy` is 1 from the edge that samples a start until the completion edge, and it is 0 afterwards outside free-running mode. Start strobes and triggers sampled while `busy` is 1 are ignored.
- R8: In free-running mode (`mode` = 2) a new 13-cycle conversion begins on the completion edge with no new start. Leaving that mode lets the running conversion finish, and then the block goes idle.
- R9: In trigger mode (`mode` = 1) a `trig` pulse starts a conversion with the same timing as a start strobe. In single mode (`mode` = 0, or 3) `trig` has no effect.
- R10: `presc_sel` values 0 to 6 give D = 2^(presc_sel+1), and 7 gives D = 128.
- R11: With `en` low, any running or pending conversion is dropped, `busy` is 0 and starts are ignored. The next conversion after re-enabling is a 25-cycle one.
- R12: The result is `ana_code` as latched at sample-and-hold and is right-aligned. `res_lo` holds bits 7:0 and `res_hi` holds the upper bits, zero-padded. Both bytes change together on the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| mode | input | 2 | 0 single, 1 trigger, 2 free-running, 3 single |
| presc_sel | input | 3 | Converter clock divider select |
| start_wr | input | 1 | Start strobe (software write of the start bit) |
| trig | input | 1 | External trigger pulse |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| sel_wr_en | input | 1 | Holding register write enable |
| sel_wr_data | input | SEL_W | Channel and reference selection |
| ana_code | input | RES_W | Code returned by the analog stub |
| mux_sel | output | SEL_W | Shadow selection driving the multiplexer |
| busy | output | 1 | Start bit readback: pending or converting |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | Result upper byte |
| res_lo | output | 8 | Result lower byte |

## Verification
The bench builds the block with its defaults: a 5-bit selection, a 10-bit result, conversion lengths of 25 and 13, and a release window of 8. A 10-bit result makes the upper byte carry real bits, so the split and the zero padding of `res_hi` can be observed. Most runs use divider select 0, where a conversion takes 26 or 50 clocks. At that speed the exact lock and release edges, free-running chains and the trigger path can all be checked in a short run. Selects 2 and 7 are also run, which covers both a middle ratio and the largest one.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_FREE   = 2'd2,
    MODE_ALT    = 2'd3
  } adc_mode_e;

  // division ratio minus one for a 3-bit select; 7 saturates at 128
  function automatic logic [7:0] div_limit(input logic [2:0] sel);
    logic [2:0] s_eff;
    s_eff = (sel == 3'd7) ? 3'd6 : sel;
    return 8'((9'd2 << s_eff) - 9'd1);
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
`timescale 1ns/1ps
module adc_prescaler #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import adc_seq_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(div_limit(sel));
    tick = run && (cnt_q == lim);
  end

  // held at zero when idle: each conversion starts on a clean boundary
  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sel_shadow.sv
`timescale 1ns/1ps
module adc_sel_shadow #(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             upd_open,
  output logic [SEL_W-1:0] shadow
);
  logic [SEL_W-1:0] hold_q;
  logic [SEL_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shadow_q <= '0;
    else if (upd_open) shadow_q <= hold_q;
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/adc_core_stub.sv
`timescale 1ns/1ps
module adc_core_stub #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] ana_code,
  output logic [RES_W-1:0] code
);
  logic [RES_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       code_q <= '0;
    else if (capture) code_q <= ana_code;
  end

  assign code = code_q;
endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int SEL_W     = 5,
  parameter int RES_W     = 10,
  parameter int LEN_FIRST = 25,
  parameter int LEN_NORM  = 13,
  parameter int OPEN_WIN  = 8,
  parameter int SH_FIRST  = 13,
  parameter int SH_NORM   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [2:0]       presc_sel,
  input  logic             start_wr,
  input  logic             trig,
  input  logic             flag_clr,
  input  logic             sel_wr_en,
  input  logic [SEL_W-1:0] sel_wr_data,
  input  logic [RES_W-1:0] ana_code,
  output logic [SEL_W-1:0] mux_sel,
  output logic             busy,
  output logic             done_flag,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  import adc_seq_pkg::*;

  localparam int CYC_W = $clog2(LEN_FIRST + 1);
  localparam logic [CYC_W-1:0] LAST_F = CYC_W'(LEN_FIRST - 1);
  localparam logic [CYC_W-1:0] LAST_N = CYC_W'(LEN_NORM - 1);
  localparam logic [CYC_W-1:0] OPEN_F = CYC_W'(LEN_FIRST - OPEN_WIN);
  localparam logic [CYC_W-1:0] OPEN_N = CYC_W'(LEN_NORM - OPEN_WIN);
  localparam logic [CYC_W-1:0] SAMP_F = CYC_W'(SH_FIRST);
  localparam logic [CYC_W-1:0] SAMP_N = CYC_W'(SH_NORM);

  logic             req_a, req_b, conv_run, first_q;
  logic [CYC_W-1:0] cyc_q;
  logic             adc_tick;
  logic             win_open, conv_last, samp_now, go;
  logic [CYC_W-1:0] last_cyc, open_cyc, samp_cyc;
  logic [RES_W-1:0] stub_code;
  logic [RES_W-1:0] res_q;

  always_comb begin
    last_cyc  = first_q ? LAST_F : LAST_N;
    open_cyc  = first_q ? OPEN_F : OPEN_N;
    samp_cyc  = first_q ? SAMP_F : SAMP_N;
    busy      = req_a | req_b | conv_run;
    go        = en && !busy &&
                (start_wr || ((mode == MODE_AUTO) && trig));
    win_open  = !conv_run || (cyc_q >= open_cyc);
    conv_last = conv_run && adc_tick && (cyc_q == last_cyc);
    samp_now  = conv_run && adc_tick && (cyc_q == samp_cyc);
  end

  adc_prescaler #(.CNT_W(7)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (conv_run),
    .sel  (presc_sel),
    .tick (adc_tick)
  );

  adc_sel_shadow #(.SEL_W(SEL_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr_en),
    .wr_data (sel_wr_data),
    .upd_open(win_open),
    .shadow  (mux_sel)
  );

  adc_core_stub #(.RES_W(RES_W)) u_stub (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (samp_now),
    .ana_code(ana_code),
    .code    (stub_code)
  );

  // start pipeline: sample edge -> req_a -> req_b -> conversion runs
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      req_a    <= 1'b0;
      req_b    <= 1'b0;
      conv_run <= 1'b0;
      cyc_q    <= '0;
      first_q  <= 1'b1;
    end else begin
      req_a <= go;
      req_b <= req_a;
      if (req_b) begin
        conv_run <= 1'b1;
        cyc_q    <= '0;
      end else if (conv_run && adc_tick) begin
        if (cyc_q == last_cyc) begin
          cyc_q    <= '0;
          first_q  <= 1'b0;
          conv_run <= (mode == MODE_FREE);
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         done_flag <= 1'b0;
    else if (conv_last) done_flag <= 1'b1;
    else if (flag_clr)  done_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         res_q <= '0;
    else if (conv_last) res_q <= stub_code;
  end

  generate
    if (RES_W > 8) begin : g_wide
      assign res_hi = 8'(res_q >> 8);
      assign res_lo = res_q[7:0];
    end else begin : g_narrow
      assign res_hi = 8'd0;
      assign res_lo = 8'(res_q);
    end
  endgenerate
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       mode,
  input logic             req_a,
  input logic             req_b,
  input logic             conv_run,
  input logic             win_open,
  input logic             conv_last,
  input logic             busy,
  input logic             done_flag,
  input logic [SEL_W-1:0] mux_sel
);
  import adc_seq_pkg::*;

  // R4: locked state before an edge keeps the multiplexer selection
  assert_shadow_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_run && !win_open) |-> $stable(mux_sel));

  // R5: completion raises the flag on the next sample
  assert_flag_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_last |=> done_flag);

  // R3: a conversion only begins from the second pipeline stage
  assert_start_two_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_run) |-> $past(req_b));

  // R7: pending and running stages never overlap
  assert_stages_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_a, req_b, conv_run}));

  // R7: outside free-running, completion ends busy
  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_last && (mode != MODE_FREE)) |=> !busy);

  // R8: free-running keeps converting past completion
  assert_free_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_last && (mode == MODE_FREE) && en) |=> busy);
endmodule

bind adc_seq adc_seq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .mode     (mode),
  .req_a    (req_a),
  .req_b    (req_b),
  .conv_run (conv_run),
  .win_open (win_open),
  .conv_last(conv_last),
  .busy     (busy),
  .done_flag(done_flag),
  .mux_sel  (mux_sel)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  localparam int SEL_W = 5;
  localparam int RES_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [2:0]       presc_sel = 3'd0;
  logic             start_wr = 1'b0;
  logic             trig = 1'b0;
  logic             flag_clr = 1'b0;
  logic             sel_wr_en = 1'b0;
  logic [SEL_W-1:0] sel_wr_data = '0;
  logic [RES_W-1:0] ana_code = '0;
  logic [SEL_W-1:0] mux_sel;
  logic             busy, done_flag;
  logic [7:0]       res_hi, res_lo;

  always #2.5 clk = ~clk;

  adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .presc_sel(presc_sel),
    .start_wr(start_wr), .trig(trig), .flag_clr(flag_clr),
    .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .ana_code(ana_code),
    .mux_sel(mux_sel), .busy(busy), .done_flag(done_flag),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  int unsigned cyc_n = 0;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  sim_over = 0;

  typedef struct { int unsigned at; int unsigned code; } exp_t;
  exp_t exp_q[$];
  bit          first_exp = 1;
  int unsigned div_b = 2;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!sim_over) begin
      sim_over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected completion edge and result, from R6/R10/R12
  task automatic push_conv(input int unsigned k, input int unsigned code);
    int unsigned len;
    len = first_exp ? 25 : 13;
    exp_q.push_back('{k + 2 + len * div_b, code});
    first_exp = 0;
  endtask

  task automatic drive_start(output int unsigned k);
    @(negedge clk);
    start_wr = 1'b1;
    k = cyc_n + 1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic drive_trig(output int unsigned k);
    @(negedge clk);
    trig = 1'b1;
    k = cyc_n + 1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_to(input int unsigned t);
    while (cyc_n < t) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || busy || flag_clr) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every completion, then clears the flag
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (flag_clr) begin
        flag_clr = 1'b0;
        check(!done_flag, "R5", "flag after write-one clear", done_flag, 0);
      end else if (rst_n && done_flag) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected completion edge", cyc_n, 0);
        end else begin
          e = exp_q.pop_front();
          check(cyc_n == e.at, "R6", "completion edge", cyc_n, e.at);
          check({res_hi, res_lo} == 16'(e.code), "R12", "result pair",
                {res_hi, res_lo}, e.code);
        end
        flag_clr = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired, completions left", exp_q.size(), 0);
    summary();
  end

  initial begin
    int unsigned k;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(busy == 0 && done_flag == 0, "R1", "busy/flag after reset",
          {busy, done_flag}, 0);
    check(mux_sel == 0 && {res_hi, res_lo} == 0, "R1", "selection/result after reset",
          {mux_sel, res_hi, res_lo}, 0);

    // R11: start ignored while disabled
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    @(negedge clk);
    check(busy == 0, "R11", "busy after start while disabled", busy, 0);
    en = 1'b1;

    // R2: idle tracking, one edge behind the write
    sel_wr_en = 1'b1; sel_wr_data = 5'h0A;
    @(negedge clk);
    sel_wr_en = 1'b0;
    check(mux_sel == 0, "R2", "mux one edge after write", mux_sel, 0);
    @(negedge clk);
    check(mux_sel == 5'h0A, "R2", "mux two edges after write", mux_sel, 5'h0A);

    // first conversion (R6 25 cycles), busy and ignored restart (R7)
    ana_code = 10'd300;
    drive_start(k);
    push_conv(k, 300);
    check(busy == 1, "R7", "busy right after start sample", busy, 1);
    wait_to(k + 5);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    wait_idle();
    check(busy == 0, "R7", "busy after completion", busy, 0);

    // R3/R4: lock edges, 13-cycle conversion, D = 2
    ana_code = 10'd77;
    drive_start(k);
    push_conv(k, 77);
    sel_wr_en = 1'b1; sel_wr_data = 5'h11;   // sampled on k+1
    @(negedge clk);
    sel_wr_data = 5'h1E;                     // sampled on k+2
    @(negedge clk);
    sel_wr_en = 1'b0;
    check(mux_sel == 5'h11, "R3", "write on k+1 reaches mux", mux_sel, 5'h11);
    @(negedge clk);
    check(mux_sel == 5'h11, "R3", "write on k+2 held back", mux_sel, 5'h11);
    wait_to(k + 2 + 5 * 2);
    check(mux_sel == 5'h11, "R4", "mux frozen at window edge", mux_sel, 5'h11);
    @(negedge clk);
    check(mux_sel == 5'h1E, "R4", "mux released in window", mux_sel, 5'h1E);
    wait_idle();

    // R10: divider selects 2 and 7; R12 upper byte
    presc_sel = 3'd2; div_b = 8; ana_code = 10'd1023;
    drive_start(k);
    push_conv(k, 1023);
    wait_idle();
    check(res_hi == 8'h03 && res_lo == 8'hFF, "R12", "byte split of 1023",
          {res_hi, res_lo}, 16'h03FF);
    presc_sel = 3'd7; div_b = 128; ana_code = 10'd512;
    drive_start(k);
    push_conv(k, 512);
    wait_idle();
    presc_sel = 3'd0; div_b = 2;

    // R9: trigger ignored in single mode, used in trigger mode
    mode = 2'd0;
    drive_trig(k);
    check(busy == 0, "R9", "busy after trigger in single mode", busy, 0);
    @(negedge clk);
    check(busy == 0, "R9", "busy later in single mode", busy, 0);
    mode = 2'd1; ana_code = 10'd258;
    drive_trig(k);
    push_conv(k, 258);
    check(busy == 1, "R9", "busy after trigger in trigger mode", busy, 1);
    wait_idle();

    // R8: free-running chain of three, then leave the mode
    mode = 2'd2; ana_code = 10'd400;
    drive_start(k);
    push_conv(k, 400);
    exp_q.push_back('{k + 2 + 26 * 2, 400});
    exp_q.push_back('{k + 2 + 26 * 3, 400});
    while (exp_q.size() > 1) @(negedge clk);
    check(busy == 1, "R8", "busy between free-running conversions", busy, 1);
    mode = 2'd0;
    wait_idle();
    repeat (40) @(negedge clk);
    check(busy == 0, "R8", "idle after leaving free-running", busy, 0);

    // R11: abort by disable, then a 25-cycle conversion
    ana_code = 10'd9;
    drive_start(k);
    wait_to(k + 10);
    en = 1'b0;
    @(negedge clk);
    check(busy == 0, "R11", "busy after disable", busy, 0);
    en = 1'b1;
    first_exp = 1;
    drive_start(k);
    push_conv(k, 9);
    wait_idle();
    check(done_flag == 0, "R5", "flag left cleared", done_flag, 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule